// File: doc/BRIEF.md
# Dual-Reload PWM Timer Bank

This block holds a bank of independent down-counting timers. Each channel drives one output pin. The low phase and the high phase of that pin each take their length from their own reload register. A simple write strobe with an address and 32-bit data programs the channels. A combinational read port returns any register. Software uses it to make pulse trains of any duty, each phase lasting from 1 to 2^32 clock cycles.

Each channel has two waveform settings:
- **Split-phase:** the low phase lasts low-reload + 1 cycles and the high phase lasts high-reload + 1 cycles.
- **Symmetric:** only the low reload is used, which gives a square wave with 50% duty.

A started channel always opens with its low phase. A reload value written while the channel runs reaches the counter at once. There is no need to stop and restart the channel first.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: The channel index is addr[6:5], so channels are 0x20 apart. Within a channel, offset 0x00 is the low reload, offset 0x14 is the high reload and offset 0x04 is control. Control uses bit0 run, bit1 reload-mode and bit4 split-phase, and reads back only those bits. Any other offset reads 0 and ignores writes.
- R3: A control write that sets run on a stopped channel loads the low reload into the counter and starts the low phase. The output then stays low for low-reload + 1 cycles.
- R4: With split-phase set, the output alternates between a low phase of low-reload + 1 cycles and a high phase of high-reload + 1 cycles.
- R5: With split-phase clear, both phases last low-reload + 1 cycles and the high reload has no effect.
- R6: At each phase expiry the counter reloads from the register of the phase being entered, so every later period repeats the programmed lengths.
- R7: A control write that clears run drives the output low from the next cycle. A later start again begins with a full low phase.
- R8: While running, a write to the reload register of the current phase loads the counter at once, so the phase ends after value + 1 more cycles. A write to the other reload register leaves the current phase unchanged.
- R9: When a reload write falls in the cycle of a phase expiry, the expiry wins: the output toggles, and the counter takes the entered phase's reload value, including data written in that same cycle.
- R10: Channels are independent: writes to one channel change neither the registers nor the output of another.
- R11: Reload registers hold all 32 bits, and the value 0xFFFFFFFF yields a phase longer than 1000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address: channel in [6:5], offset in [4:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
Two functions can fall in the same cycle: a phase expiry and a software write to the reload register that the expiry is about to use. The bench starts a channel with a known low reload and counts clock edges so that the write strobe lands exactly in the cycle where the counter sits at zero. It does this in both symmetric and split-phase settings. It then judges the outcome by the lengths of the following phases: the output must toggle on time, and the entered phase must take the freshly written value where that register applies.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int CNT_W = 32;
  localparam int OFS_W = 5;
  localparam logic [OFS_W-1:0] OFS_LOW  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL = 5'h04;
  localparam logic [OFS_W-1:0] OFS_HIGH = 5'h14;
  localparam int BIT_RUN   = 0;
  localparam int BIT_MODE  = 1;
  localparam int BIT_SPLIT = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic split;
    logic mode;
    logic run;
  } ctrl_t;

  // Control register image as seen by software.
  function automatic cnt_t ctrl_word(ctrl_t c);
    cnt_t w;
    w = '0;
    w[BIT_RUN]   = c.run;
    w[BIT_MODE]  = c.mode;
    w[BIT_SPLIT] = c.split;
    return w;
  endfunction

  // True when the running phase is timed by the high reload.
  function automatic logic phase_uses_high(logic split, logic out_hi);
    return split & out_hi;
  endfunction

  // Counter value for the phase entered at expiry.
  function automatic cnt_t next_load(logic split, logic out_hi, cnt_t lo, cnt_t hi);
    return (split && !out_hi) ? hi : lo;
  endfunction
endpackage

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan
  import pwm_tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_low,
  input  logic  wr_ctrl,
  input  logic  wr_high,
  input  cnt_t  wdata,
  output cnt_t  low_q,
  output cnt_t  high_q,
  output ctrl_t ctrl_q,
  output logic  out_q
);
  cnt_t cnt_q;
  cnt_t low_nx, high_nx;
  logic en_rise, dis_evt, expire, cur_hi_reg, live_wr, running;

  assign low_nx     = wr_low  ? wdata : low_q;
  assign high_nx    = wr_high ? wdata : high_q;
  assign en_rise    = wr_ctrl && wdata[BIT_RUN] && !ctrl_q.run;
  assign dis_evt    = wr_ctrl && !wdata[BIT_RUN];
  assign running    = ctrl_q.run && !dis_evt;
  assign expire     = running && (cnt_q == '0);
  assign cur_hi_reg = phase_uses_high(ctrl_q.split, out_q);
  assign live_wr    = running && (cur_hi_reg ? wr_high : wr_low);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_low)  low_q  <= wdata;
      if (wr_high) high_q <= wdata;
      if (wr_ctrl) ctrl_q <= '{split: wdata[BIT_SPLIT], mode: wdata[BIT_MODE],
                               run: wdata[BIT_RUN]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (en_rise) begin
      cnt_q <= low_nx;
      out_q <= 1'b0;
    end else if (!running) begin
      out_q <= 1'b0;
    end else if (expire) begin
      out_q <= ~out_q;
      cnt_q <= next_load(ctrl_q.split, out_q, low_nx, high_nx);
    end else if (live_wr) begin
      cnt_q <= wdata;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (!out_q && cnt_q == $past(low_nx)));
  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !out_q);
  // R4
  expire_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (out_q != $past(out_q)));
  // R5
  sym_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.split) |=> (cnt_q == $past(low_nx)));
  // R8
  live_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_wr && !expire) |=> (cnt_q == $past(wdata) && $stable(out_q)));
  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !expire && !live_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwm_tmr_rdmux.sv
module pwm_tmr_rdmux
  import pwm_tmr_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int CH_W = 2
) (
  input  logic [CH_W-1:0]  ch,
  input  logic [OFS_W-1:0] ofs,
  input  cnt_t             low_all  [N_CH],
  input  cnt_t             high_all [N_CH],
  input  ctrl_t            ctrl_all [N_CH],
  output cnt_t             rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch == CH_W'(i)) begin
        case (ofs)
          OFS_LOW:  rdata = low_all[i];
          OFS_HIGH: rdata = high_all[i];
          OFS_CTRL: rdata = ctrl_word(ctrl_all[i]);
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_tmr_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int ADDR_W = CH_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [N_CH-1:0]   pwm_out
);
  logic [CH_W-1:0]  ch_sel;
  logic [OFS_W-1:0] ofs;
  cnt_t  low_all  [N_CH];
  cnt_t  high_all [N_CH];
  ctrl_t ctrl_all [N_CH];

  assign ch_sel = addr[ADDR_W-1:OFS_W];
  assign ofs    = addr[OFS_W-1:0];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (ch_sel == CH_W'(g));
    pwm_tmr_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_low  (hit && ofs == OFS_LOW),
      .wr_ctrl (hit && ofs == OFS_CTRL),
      .wr_high (hit && ofs == OFS_HIGH),
      .wdata   (wdata),
      .low_q   (low_all[g]),
      .high_q  (high_all[g]),
      .ctrl_q  (ctrl_all[g]),
      .out_q   (pwm_out[g])
    );
  end

  pwm_tmr_rdmux #(.N_CH(N_CH), .CH_W(CH_W)) u_rdmux (
    .ch       (ch_sel),
    .ofs      (ofs),
    .low_all  (low_all),
    .high_all (high_all),
    .ctrl_all (ctrl_all),
    .rdata    (rdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (pwm_out == '0));
endmodule

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb;
  localparam int AW = 7;
  localparam int CAP = 1000;
  localparam logic [31:0] C_SPLIT = 32'h13;
  localparam logic [31:0] C_SYM   = 32'h03;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] pwm_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pwm_timer_bank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  function automatic int exp_low(int lo); return lo + 1; endfunction
  function automatic int exp_high(bit split, int lo, int hi);
    return split ? hi + 1 : lo + 1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int ofs, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(ch * 32 + ofs); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int ch, int ofs, output logic [31:0] d);
    @(negedge clk); addr = AW'(ch * 32 + ofs); #1; d = rdata;
  endtask

  task automatic run_len(int ch, logic lvl, output int n);
    n = 0;
    while (pwm_out[ch] == lvl && n < CAP) begin n++; @(negedge clk); end
  endtask

  task automatic start(int ch, logic [31:0] lo, logic [31:0] hi, bit split);
    wr(ch, 4, 0); wr(ch, 0, lo); wr(ch, 'h14, hi);
    wr(ch, 4, split ? C_SPLIT : C_SYM);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 outputs", 32'(pwm_out), 0);
    for (int c = 0; c < 4; c++) begin
      rd(c, 0, d); chk("R1 low reg", d, 0);
      rd(c, 4, d); chk("R1 ctrl reg", d, 0);
      rd(c, 'h14, d); chk("R1 high reg", d, 0);
    end
    // R2 map and readback
    wr(2, 0, 32'hA5A5_0001); wr(2, 'h14, 32'h0000_BEEF);
    wr(2, 8, 32'h1234_5678);
    rd(2, 0, d); chk("R2 low readback", d, 32'hA5A5_0001);
    rd(2, 'h14, d); chk("R2 high readback", d, 32'h0000_BEEF);
    rd(2, 8, d); chk("R2 unmapped reads 0", d, 0);
    wr(3, 4, 32'hFFFF_FFFF);
    rd(3, 4, d); chk("R2 ctrl bits only", d, 32'h13);
    wr(3, 4, 0);
    // R10 independence
    rd(0, 0, d); chk("R10 ch0 untouched", d, 0);
    rd(1, 'h14, d); chk("R10 ch1 untouched", d, 0);
    // R3 R4 directed split-phase
    begin
      int lo_v[4] = '{0, 0, 5, 2};
      int hi_v[4] = '{0, 3, 0, 7};
      for (int k = 0; k < 4; k++) begin
        start(0, lo_v[k], hi_v[k], 1);
        run_len(0, 0, n); chk("R3 first low", n, exp_low(lo_v[k]));
        run_len(0, 1, n); chk("R4 high", n, exp_high(1, lo_v[k], hi_v[k]));
      end
    end
    // R5 symmetric, high reload ignored
    start(1, 3, 9, 0);
    run_len(1, 0, n); chk("R5 low", n, 4);
    run_len(1, 1, n); chk("R5 high ignores high reg", n, 4);
    // R10 other channels quiet while ch0 and ch1 run
    repeat (20) begin
      @(negedge clk); chk("R10 ch3 idle", 32'(pwm_out[3]), 0);
    end
    wr(1, 4, 0);
    // R6 random, repeated periods
    for (int it = 0; it < 12; it++) begin
      int ch = $urandom % 4;
      int lo = $urandom % 12;
      int hi = $urandom % 12;
      bit sp = 1'($urandom % 2);
      start(ch, lo, hi, sp);
      for (int p = 0; p < 2; p++) begin
        run_len(ch, 0, n); chk("R6 low", n, exp_low(lo));
        run_len(ch, 1, n); chk("R6 high", n, exp_high(sp, lo, hi));
      end
      wr(ch, 4, 0);
    end
    // R7 disable mid-high, restart low
    start(0, 3, 6, 1);
    run_len(0, 0, n);
    @(negedge clk);
    wr(0, 4, 0);
    chk("R7 low after stop", 32'(pwm_out[0]), 0);
    repeat (10) @(negedge clk);
    chk("R7 stays low", 32'(pwm_out[0]), 0);
    wr(0, 4, C_SPLIT);
    run_len(0, 0, n); chk("R7 restart full low", n, 4);
    // R8 live write to current-phase register
    start(0, 10, 2, 1);
    wr(0, 0, 1);
    run_len(0, 0, n); chk("R8 live low", n, 2);
    run_len(0, 1, n); chk("R8 high after live", n, 3);
    // R8 write to other register leaves current phase
    start(0, 6, 2, 1);
    wr(0, 'h14, 4);
    run_len(0, 0, n); chk("R8 low unaffected", n, 5);
    run_len(0, 1, n); chk("R8 new high", n, 5);
    // R9 collision: write low reload in the expiry cycle, symmetric
    start(0, 3, 9, 0);
    repeat (2) @(negedge clk);
    wr(0, 0, 5);
    chk("R9 toggled on time", 32'(pwm_out[0]), 1);
    run_len(0, 1, n); chk("R9 sym high takes new", n, 6);
    run_len(0, 0, m); chk("R9 sym low takes new", m, 6);
    // R9 collision, split-phase
    start(0, 3, 2, 1);
    repeat (2) @(negedge clk);
    wr(0, 0, 5);
    chk("R9 split toggled", 32'(pwm_out[0]), 1);
    run_len(0, 1, n); chk("R9 split high", n, 3);
    run_len(0, 0, m); chk("R9 split low new", m, 6);
    // R11 full width
    start(0, 32'hFFFF_FFFF, 0, 1);
    rd(0, 0, d); chk("R11 readback", d, 32'hFFFF_FFFF);
    run_len(0, 0, n); chk("R11 long low", n, CAP);
    wr(0, 4, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule